// File: doc/BRIEF.md
# Memory Bank Control and Strobe Decoder

This block sits between a processor's address translation and its external memory pins. Each access arrives as a 20-bit physical address with a read or write flag. The top two address bits pick one of four 256K quadrants, and that quadrant's 8-bit control register decides how the access reaches the pins. It picks which of three active-low chip selects is driven and which output-enable/write-enable pair is used. It can flip the two top address lines, block the write strobe, and stretch the bus cycle by a programmed number of wait states.

The control registers are written over a simple I/O write port and cannot be read back. A separate global register can hold chip select 1 asserted at all times, so a memory that tolerates it never sees select toggling. The settings of the addressed quadrant are captured when an access is accepted. Register writes made during a cycle therefore apply from the next access. A one-clock done pulse marks the last clock of every bus cycle.

Top module: `mbank_strobe_ctl`

## Requirements
- R1: After reset all four bank registers and the global register are zero. When idle, `cs_n`=3'b111, `oe_n`=2'b11, `we_n`=2'b11, `cyc_done`=0 and `mem_addr`=0. With the reset settings, every quadrant gives a 6-clock read on chip select 0 using strobe pair 0.
- R2: `req_addr[19:18]` selects the bank register at I/O address 0x14+quadrant. The selection uses the untranslated address, before any line inversion.
- R3: Register bits 7:6 set the wait states: 00 gives 4, 01 gives 2, 10 gives 1 and 11 gives 0. A read lasts 2 clocks plus the wait states and a write lasts 3 clocks plus the wait states. `cyc_done` is high only in the final clock of the cycle.
- R4: During a cycle, `mem_addr` equals the request address with bit 19 inverted when register bit 5 is set and bit 18 inverted when register bit 4 is set. Bits 17:0 pass unchanged. Only accesses to that register's quadrant are affected.
- R5: Register bits 1:0 pick the chip select held low for the whole cycle: 00 gives `cs_n[0]`, 01 gives `cs_n[1]`, and 10 or 11 gives `cs_n[2]`. The other selects stay high unless R9 applies.
- R6: Register bit 2 picks the strobe pair: 0 uses `oe_n[0]`/`we_n[0]` and 1 uses `oe_n[1]`/`we_n[1]`. The unused pair stays high.
- R7: On a read, the selected `oe_n` is low in every clock of the cycle and both `we_n` stay high. On a write, the selected `we_n` is low in every clock except the first and the last, and both `oe_n` stay high.
- R8: With register bit 3 set, writes to that quadrant keep both `we_n` high. The cycle still runs its full length and ends with `cyc_done`.
- R9: Writing I/O address 0x10 with bit 5 set holds `cs_n[1]` low continuously, including while idle. Writing it with bit 5 clear releases `cs_n[1]`.
- R10: A request is accepted only when no cycle is active, and requests made during a cycle are ignored. The quadrant's settings are captured at acceptance, so a register write during a cycle affects only later cycles.
- R11: I/O writes to addresses other than 0x10 and 0x14–0x17 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr_en | input | 1 | I/O register write strobe |
| io_addr | input | 8 | I/O register address |
| io_wdata | input | 8 | I/O register write data |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 20 | Physical address of the access |
| mem_addr | output | 20 | Address to memory after line inversion |
| cs_n | output | 3 | Active-low chip selects |
| oe_n | output | 2 | Active-low output enables, one per pair |
| we_n | output | 2 | Active-low write enables, one per pair |
| cyc_done | output | 1 | High in the final clock of a bus cycle |

## Verification
The hardest case to reach from the ports is a register change that lands inside a running cycle. The quadrant's own register is rewritten while its cycle is under way, and a second request is raised in the middle of that cycle. The stimulus holds a long 4-wait-state read on quadrant 3 and, in its second clock, rewrites that quadrant's register to zero wait states. One clock later it raises a competing write request. The cycle must still run its original 6 clocks with no second cycle following it, and only the next access may show the new 2-clock timing. Quadrant selection before inversion is covered by inverting both top lines on quadrant 3, so the driven address falls into quadrant 0 while quadrant 3's chip select stays in use.

// File: rtl/mbank_pkg.sv
package mbank_pkg;

    localparam int ADDR_W    = 20;
    localparam int NUM_BANKS = 4;
    localparam int QSEL_W    = $clog2(NUM_BANKS);
    localparam int N_CS      = 3;
    localparam int N_PAIR    = 2;
    localparam int IO_AW     = 8;
    localparam int IO_DW     = 8;
    localparam int MAX_WAIT  = 4;
    localparam int BASE_RD   = 2;
    localparam int BASE_WR   = 3;
    localparam int MAX_LEN   = BASE_WR + MAX_WAIT;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);
    localparam int CS_IDX_W  = $clog2(N_CS);
    localparam int PAIR_W    = $clog2(N_PAIR);

    // Field order matches the bit positions the decoder relies on.
    typedef struct packed {
        logic [1:0] ws_code;   // 7:6
        logic       inv_hi;    // 5
        logic       inv_lo;    // 4
        logic       wr_block;  // 3
        logic       pair_sel;  // 2
        logic [1:0] cs_code;   // 1:0
    } bank_ctl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              is_write;
        bank_ctl_t         ctl;
    } cycle_t;

    function automatic logic [CNT_W-1:0] wait_states(input logic [1:0] code);
        logic [CNT_W-1:0] ws;
        unique case (code)
            2'b00:   ws = CNT_W'(MAX_WAIT);
            2'b01:   ws = CNT_W'(MAX_WAIT / 2);
            2'b10:   ws = CNT_W'(1);
            default: ws = '0;
        endcase
        return ws;
    endfunction

    function automatic logic [CNT_W-1:0] cycle_len(input logic [1:0] code,
                                                   input logic       wr);
        logic [CNT_W-1:0] base;
        base = wr ? CNT_W'(BASE_WR) : CNT_W'(BASE_RD);
        return base + wait_states(code);
    endfunction

    function automatic logic [CS_IDX_W-1:0] cs_index(input logic [1:0] code);
        logic [CS_IDX_W-1:0] idx;
        if (code[1])      idx = CS_IDX_W'(2);
        else if (code[0]) idx = CS_IDX_W'(1);
        else              idx = '0;
        return idx;
    endfunction

    function automatic logic [ADDR_W-1:0] remap_addr(input logic [ADDR_W-1:0] a,
                                                     input bank_ctl_t         c);
        logic [ADDR_W-1:0] r;
        r = a;
        r[ADDR_W-1] = a[ADDR_W-1] ^ c.inv_hi;
        r[ADDR_W-2] = a[ADDR_W-2] ^ c.inv_lo;
        return r;
    endfunction

endpackage

// File: rtl/mbank_regfile.sv
module mbank_regfile
    import mbank_pkg::*;
#(
    parameter logic [IO_AW-1:0] IO_BASE   = 8'h14,
    parameter logic [IO_AW-1:0] GLOBAL_IO = 8'h10,
    parameter int               FORCE_BIT = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        io_wr_en,
    input  logic [IO_AW-1:0]            io_addr,
    input  logic [IO_DW-1:0]            io_wdata,
    output bank_ctl_t [NUM_BANKS-1:0]   ctl_o,
    output logic                        force_cs_o
);

    logic [NUM_BANKS-1:0] hit;
    logic                 glob_hit;

    assign glob_hit = io_wr_en && (io_addr == GLOBAL_IO);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign hit[b] = io_wr_en && (io_addr == IO_BASE + IO_AW'(b));

        always_ff @(posedge clk) begin
            if (rst)         ctl_o[b] <= '0;
            else if (hit[b]) ctl_o[b] <= bank_ctl_t'(io_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           force_cs_o <= 1'b0;
        else if (glob_hit) force_cs_o <= io_wdata[FORCE_BIT];
    end

    assert_other_io_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        !(|hit) |=> $stable(ctl_o));

    assert_force_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !glob_hit |=> $stable(force_cs_o));

endmodule

// File: rtl/mbank_cycle_seq.sv
module mbank_cycle_seq
    import mbank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  bank_ctl_t [NUM_BANKS-1:0]  ctl_i,
    output logic                       active_o,
    output cycle_t                     cur_o,
    output logic [CNT_W-1:0]           cnt_o,
    output logic                       last_o
);

    logic [QSEL_W-1:0] quad;
    bank_ctl_t         sel_ctl;
    logic [CNT_W-1:0]  len_q;

    assign quad    = req_addr[ADDR_W-1 -: QSEL_W];
    assign sel_ctl = ctl_i[quad];
    assign last_o  = active_o && (cnt_o == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
            len_q    <= '0;
            cur_o    <= '0;
        end else if (!active_o) begin
            if (req_valid) begin
                active_o       <= 1'b1;
                cnt_o          <= '0;
                len_q          <= cycle_len(sel_ctl.ws_code, req_write);
                cur_o.addr     <= req_addr;
                cur_o.is_write <= req_write;
                cur_o.ctl      <= sel_ctl;
            end
        end else if (last_o) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
        end else begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !last_o);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        active_o |-> (cnt_o < CNT_W'(MAX_LEN)));

    assert_snapshot_held_R10: assert property (@(posedge clk) disable iff (rst)
        (active_o && $past(active_o) && !$past(last_o)) |-> $stable(cur_o));

endmodule

// File: rtl/mbank_strobe_drv.sv
module mbank_strobe_drv
    import mbank_pkg::*;
#(
    parameter int FORCE_CS = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active_i,
    input  cycle_t             cur_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               last_i,
    input  logic               force_cs_i,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [N_CS-1:0]    cs_n,
    output logic [N_PAIR-1:0]  oe_n,
    output logic [N_PAIR-1:0]  we_n,
    output logic               done
);

    logic [CS_IDX_W-1:0] cs_idx;
    logic                mid_clk;
    logic                we_allow;

    assign cs_idx   = cs_index(cur_i.ctl.cs_code);
    assign mid_clk  = (cnt_i != '0) && !last_i;
    assign we_allow = active_i && cur_i.is_write && !cur_i.ctl.wr_block && mid_clk;
    assign mem_addr = active_i ? remap_addr(cur_i.addr, cur_i.ctl) : '0;
    assign done     = last_i;

    for (genvar c = 0; c < N_CS; c++) begin : g_cs
        logic sel_here;
        assign sel_here = active_i && (cs_idx == CS_IDX_W'(c));
        if (c == FORCE_CS) begin : g_forced
            assign cs_n[c] = !(sel_here || force_cs_i);
        end else begin : g_plain
            assign cs_n[c] = !sel_here;
        end
    end

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        logic pair_here;
        assign pair_here = (cur_i.ctl.pair_sel == PAIR_W'(p));
        assign oe_n[p] = !(active_i && !cur_i.is_write && pair_here);
        assign we_n[p] = !(we_allow && pair_here);
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !active_i |-> ((&oe_n) && (&we_n) && !done));

    assert_oe_we_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        (&oe_n) || (&we_n));

    assert_we_not_last_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (&we_n));

    assert_cs_single_R5: assert property (@(posedge clk) disable iff (rst)
        (active_i && !force_cs_i) |-> ($countones(~cs_n) == 1));

    assert_wr_block_R8: assert property (@(posedge clk) disable iff (rst)
        (active_i && cur_i.ctl.wr_block) |-> (&we_n));

endmodule

// File: rtl/mbank_strobe_ctl.sv
module mbank_strobe_ctl
    import mbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               io_wr_en,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic [IO_DW-1:0]   io_wdata,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [N_CS-1:0]    cs_n,
    output logic [N_PAIR-1:0]  oe_n,
    output logic [N_PAIR-1:0]  we_n,
    output logic               cyc_done
);

    bank_ctl_t [NUM_BANKS-1:0] bank_ctl;
    logic                      force_cs;
    logic                      active;
    cycle_t                    cur;
    logic [CNT_W-1:0]          cnt;
    logic                      last;

    mbank_regfile #(
        .IO_BASE   (8'h14),
        .GLOBAL_IO (8'h10),
        .FORCE_BIT (5)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .io_wr_en   (io_wr_en),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .ctl_o      (bank_ctl),
        .force_cs_o (force_cs)
    );

    mbank_cycle_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .ctl_i     (bank_ctl),
        .active_o  (active),
        .cur_o     (cur),
        .cnt_o     (cnt),
        .last_o    (last)
    );

    mbank_strobe_drv #(
        .FORCE_CS (1)
    ) u_drv (
        .clk        (clk),
        .rst        (rst),
        .active_i   (active),
        .cur_i      (cur),
        .cnt_i      (cnt),
        .last_i     (last),
        .force_cs_i (force_cs),
        .mem_addr   (mem_addr),
        .cs_n       (cs_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .done       (cyc_done)
    );

endmodule

// File: tb/mbank_strobe_ctl_bench.sv
module mbank_strobe_ctl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_wr_en;
    logic [7:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        req_valid;
    logic        req_write;
    logic [19:0] req_addr;
    logic [19:0] mem_addr;
    logic [2:0]  cs_n;
    logic [1:0]  oe_n;
    logic [1:0]  we_n;
    logic        cyc_done;

    always #10 clk = ~clk;   // 50 MHz

    mbank_strobe_ctl u_mbank_strobe_ctl (
        .clk(clk), .rst(rst), .io_wr_en(io_wr_en), .io_addr(io_addr),
        .io_wdata(io_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .mem_addr(mem_addr), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .cyc_done(cyc_done)
    );

    typedef struct packed {
        logic [19:0] maddr;
        logic [2:0]  cs;
        logic        pair;
        logic        wr;
        logic        prot;
        int          len;
        int          start;
        logic [31:0] tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         fails  = 0;
    int         cyc    = 0;
    bit         finished = 0;
    logic [7:0] model_reg [4];
    bit         model_force;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report(input bit ok, input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic print_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Monitor: compares every clock against the scoreboard head.
    int          k;
    logic [2:0]  e_cs;
    logic [1:0]  e_oe;
    logic [1:0]  e_we;
    logic [31:0] act_v;
    logic [31:0] exp_v;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (sb.size() > 0 && cyc >= sb[0].start) begin
                k    = cyc - sb[0].start;
                e_cs = sb[0].cs;
                e_oe = 2'b11;
                e_we = 2'b11;
                if (!sb[0].wr) e_oe[sb[0].pair] = 1'b0;
                if (sb[0].wr && !sb[0].prot && k >= 1 && k <= sb[0].len - 2)
                    e_we[sb[0].pair] = 1'b0;
                act_v = {3'b0, cyc_done, cs_n, oe_n, we_n, mem_addr};
                exp_v = {3'b0, (k == sb[0].len - 1), e_cs, e_oe, e_we, sb[0].maddr};
                report(act_v == exp_v, string'(sb[0].tag),
                       $sformatf("cycle clock %0d {done,cs,oe,we,addr}", k), act_v, exp_v);
                if (k == sb[0].len - 1) void'(sb.pop_front());
            end else begin
                act_v = {26'b0, cyc_done, cs_n[0], cs_n[2], oe_n, we_n} ;
                act_v = {act_v[31:7], act_v[6:0]};
                exp_v = 32'h3f;
                act_v = {25'b0, cyc_done, cs_n[0], cs_n[2], oe_n, we_n};
                report(act_v == exp_v && mem_addr == 20'h0, "R1",
                       "idle {done,cs0,cs2,oe,we}", act_v, exp_v);
            end
        end
    end

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        io_wr_en = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr_en = 1'b0;
        if (a >= 8'h14 && a <= 8'h17) model_reg[a - 8'h14] = d;
        if (a == 8'h10) model_force = d[5];
    endtask

    function automatic exp_t make_item(input logic [19:0] a, input bit wr,
                                       input logic [31:0] tag, input int start);
        exp_t       it;
        logic [7:0] r;
        int         ws;
        r = model_reg[a[19:18]];
        case (r[7:6])
            2'b00: ws = 4;
            2'b01: ws = 2;
            2'b10: ws = 1;
            default: ws = 0;
        endcase
        it.len   = (wr ? 3 : 2) + ws;
        it.maddr = {a[19] ^ r[5], a[18] ^ r[4], a[17:0]};
        it.cs    = 3'b111;
        if (r[1])      it.cs[2] = 1'b0;
        else if (r[0]) it.cs[1] = 1'b0;
        else           it.cs[0] = 1'b0;
        if (model_force) it.cs[1] = 1'b0;
        it.pair  = r[2];
        it.wr    = wr;
        it.prot  = r[3];
        it.tag   = tag;
        it.start = start;
        return it;
    endfunction

    task automatic access(input logic [19:0] a, input bit wr, input logic [31:0] tag);
        exp_t it;
        it = make_item(a, wr, tag, cyc + 1);
        sb.push_back(it);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (it.len) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            print_summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; io_wr_en = 0; io_addr = 0; io_wdata = 0;
        req_valid = 0; req_write = 0; req_addr = 0;
        for (int i = 0; i < 4; i++) model_reg[i] = 8'h00;
        model_force = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state at the pins
        report({cs_n, oe_n, we_n, cyc_done} == 8'hFE, "R1", "reset pins",
               {24'b0, cs_n, oe_n, we_n, cyc_done}, 32'hFE);
        // R1 and R2: reset settings in every quadrant
        for (int q = 0; q < 4; q++) access({q[1:0], 18'h0_1234}, 1'b0, "R1");

        // R3 R5 R6 R7: each wait code, chip select and pair
        io_write(8'h14, 8'hC0);
        io_write(8'h15, 8'h41);
        io_write(8'h16, 8'h86);
        io_write(8'h17, 8'h07);
        for (int q = 0; q < 4; q++) begin
            access({q[1:0], 18'h2_0040}, 1'b0, "R3");
            access({q[1:0], 18'h1_0101}, 1'b1, "R7");
        end
        access(20'hC0010, 1'b1, "R6");
        access(20'h80010, 1'b0, "R5");

        // R4: line inversion, only within the programmed quadrant
        io_write(8'h16, 8'hD1);
        access(20'h80000, 1'b0, "R4");
        access(20'hBFFFF, 1'b1, "R4");
        io_write(8'h15, 8'hE0);
        access(20'h4ABCD, 1'b0, "R4");
        access(20'h12345, 1'b0, "R4");
        // R2: selection before inversion (quadrant 3 drives into quadrant 0 space)
        io_write(8'h17, 8'hF2);
        access(20'hC1234, 1'b0, "R2");
        access(20'hC1234, 1'b1, "R2");

        // R8: write inhibit keeps length, no WE
        io_write(8'h15, 8'h49);
        access(20'h40008, 1'b1, "R8");
        access(20'h40008, 1'b0, "R8");

        // R9: forced chip select 1
        io_write(8'h10, 8'h20);
        @(negedge clk);
        report(cs_n == 3'b101, "R9", "forced cs idle", {29'b0, cs_n}, 32'h5);
        access(20'h80020, 1'b0, "R9");
        access(20'h00020, 1'b1, "R9");
        io_write(8'h10, 8'h00);
        @(negedge clk);
        report(cs_n == 3'b111, "R9", "force released", {29'b0, cs_n}, 32'h7);

        // R11: stray I/O addresses and bit 5 clear at the global register
        io_write(8'h13, 8'hFF);
        io_write(8'h18, 8'hFF);
        io_write(8'h0F, 8'hFF);
        io_write(8'h10, 8'hDF);
        @(negedge clk);
        report(cs_n == 3'b111, "R11", "no force after stray writes", {29'b0, cs_n}, 32'h7);
        for (int q = 0; q < 4; q++) access({q[1:0], 18'h3_0003}, 1'b1, "R11");

        // R10: register write and competing request during a running cycle
        io_write(8'h17, 8'h07);
        begin
            exp_t it;
            it = make_item(20'hC0400, 1'b0, "R10", cyc + 1);
            sb.push_back(it);
            req_valid = 1'b1; req_write = 1'b0; req_addr = 20'hC0400;
            @(negedge clk);                       // clock 0
            req_valid = 1'b0;
            io_wr_en = 1'b1; io_addr = 8'h17; io_wdata = 8'hC0;
            @(negedge clk);                       // clock 1
            io_wr_en = 1'b0;
            model_reg[3] = 8'hC0;
            req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00000;
            @(negedge clk);                       // clock 2
            req_valid = 1'b0;
            repeat (it.len - 2) @(negedge clk);
        end
        access(20'hC0400, 1'b0, "R10");

        repeat (3) @(negedge clk);
        report(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);
        finished = 1;
        print_summary();
        $finish;
    end

endmodule